// File: doc/BRIEF.md
# Serial EEPROM Host Register Bridge

The bridge places a 16-bit-word serial EEPROM behind five byte-wide host registers. Software loads a word pointer, writes a word as a pair of bytes and then polls a handshake status. It can also read words back one byte at a time from a word that the bridge fetched in advance. A mode bit selects between read and write use. In read mode, every change of the pointer, whether written by the host or advanced after a high-byte read, starts a background fetch of the addressed word. This lets a host stream through the device with nothing but data-register reads and status polls.

The serial side is a clocked three-wire master. It has an active-high chip select, a serial clock, data out and data in, plus a ready input that the device holds low while an internal write is in progress. Each frame carries a three-bit command, the word address and sixteen data bits, all sent most significant bit first.

Top module: `seeprom_bridge`

## Requirements
- R1: After reset, the write-status register reads 8'h03, the read-status register reads 8'h00 and the pointer reads 8'h00. Chip select is low and no frame runs.
- R2: The host register offsets are pointer 0, write data 1, write status 2, read data 3 and read status 4. Register reads are combinational from addr_i. A write to offset 1 while write-status bits[1:0] are 2'b11 stores the low byte and changes those bits to 2'b10.
- R3: A write to offset 1 while bits[1:0] are 2'b10 stores the high byte, changes the bits to 2'b00 and starts a write frame of {high, low} to the word at the pointer. The bits return to 2'b11 once that write completes.
- R4: A write to offset 1 while bits[1:0] are 2'b00 is ignored. The status stays 2'b00 and the word that is stored is unaffected.
- R5: Write-status bits[6:2] always read 0. Bit 7 is the mode: 0 is read mode and 1 is write mode. A host write to offset 2 sets the mode from wdata_i[7] only and leaves bits[1:0] as they were.
- R6: In read mode, a host pointer write clears read-status bit 0 and fetches the addressed word. Bit 0 then sets, and the next two data reads return the low byte and then the high byte. The read status reads {7'b0, valid}.
- R7: A data read that returns the high byte clears valid at once and increments the pointer by one. In read mode it also fetches the next word, and valid sets again when that word arrives.
- R8: A data read while valid is clear has no effect: the pointer and the byte order are unchanged.
- R9: In write mode, pointer updates start no fetch and no serial frame, and valid stays clear.
- R10: The chip select is high for exactly one frame of 3+ADDR_W+16 clock bits. Each frame is sent MSB first and contains the command, the address and the data. The command is 3'b110 to read and 3'b101 to write. Data out changes while the serial clock is low. Data in is sampled as the serial clock rises. Each half period of the serial clock lasts CLK_DIV clocks.
- R11: After a write frame, write-status bits[1:0] stay 2'b00 until rdy_i has gone low and then high again.
- R12: If the pointer is rewritten while a fetch is in flight, the stale word is dropped. Valid sets only for the word at the new pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Host register offset |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe; side effects occur at the clock edge |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for addr_i |
| cs_o | output | 1 | Serial chip select, active high |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |
| rdy_i | input | 1 | Device ready; low while a write is in progress |

## Verification
Register effects such as status changes, the pointer increment and valid clearing appear on rdata_o in the cycle after the strobe edge. The bench drives each strobe at a falling edge and reads the result back combinationally one cycle later. A fetch becomes visible 2 + 2*CLK_DIV*(3+ADDR_W+16) edges after the pointer update, and a write becomes visible after the frame plus the device's busy time. For these results the bench polls the status at falling edges and applies a bound derived from the frame length. The check that valid stays clear is made one cycle after the update, well before the earliest possible completion.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  localparam int WORD_W = 16;
  localparam int CMD_W  = 3;
  localparam logic [CMD_W-1:0] CMD_READ  = 3'b110;
  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b101;

  localparam logic [2:0] REG_PTR   = 3'd0;
  localparam logic [2:0] REG_WDATA = 3'd1;
  localparam logic [2:0] REG_WSTAT = 3'd2;
  localparam logic [2:0] REG_RDATA = 3'd3;
  localparam logic [2:0] REG_RSTAT = 3'd4;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_WBUSY,
    ENG_WRDY
  } eng_state_e;
endpackage

// File: rtl/seeprom_shifter.sv
module seeprom_shifter
  import seeprom_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CLK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              rdy_i
);
  localparam int NB    = CMD_W + ADDR_W + WORD_W;
  localparam int IDX_W = $clog2(NB);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  eng_state_e        state_q;
  logic [NB-1:0]     frame_q;
  logic              wr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DIV_W-1:0]  div_q;
  logic              phase_q;
  logic [WORD_W-1:0] shin_q;
  logic              done_q;
  logic [WORD_W-1:0] data_sel;
  logic [CMD_W-1:0]  cmd_sel;
  logic              div_last;
  logic              idx_last;

  always_comb begin
    data_sel = is_wr_i ? wdata_i : '0;
    cmd_sel  = is_wr_i ? CMD_WRITE : CMD_READ;
  end

  assign div_last = (div_q == DIV_W'(CLK_DIV - 1));
  assign idx_last = (idx_q == IDX_W'(NB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      frame_q <= '0;
      wr_q    <= 1'b0;
      idx_q   <= '0;
      div_q   <= '0;
      phase_q <= 1'b0;
      shin_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ENG_IDLE: begin
          if (start_i) begin
            frame_q <= {cmd_sel, addr_i, data_sel};
            wr_q    <= is_wr_i;
            idx_q   <= '0;
            div_q   <= '0;
            phase_q <= 1'b0;
            state_q <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (div_last) begin
            div_q <= '0;
            if (!phase_q) begin
              phase_q <= 1'b1;
              shin_q  <= {shin_q[WORD_W-2:0], miso_i};
            end else begin
              phase_q <= 1'b0;
              frame_q <= frame_q << 1;
              if (idx_last) begin
                if (wr_q) begin
                  state_q <= ENG_WBUSY;
                end else begin
                  done_q  <= 1'b1;
                  state_q <= ENG_IDLE;
                end
              end else begin
                idx_q <= idx_q + IDX_W'(1);
              end
            end
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        ENG_WBUSY: if (!rdy_i) state_q <= ENG_WRDY;
        ENG_WRDY: begin
          if (rdy_i) begin
            done_q  <= 1'b1;
            state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ENG_IDLE);
  assign done_o  = done_q;
  assign rdata_o = shin_q;
  assign cs_o    = (state_q == ENG_SHIFT);
  assign sck_o   = (state_q == ENG_SHIFT) && phase_q;
  assign mosi_o  = (state_q == ENG_SHIFT) && frame_q[NB-1];
endmodule

// File: rtl/seeprom_regs.sv
module seeprom_regs
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              start_o,
  output logic              is_wr_o,
  output logic [ADDR_W-1:0] eaddr_o,
  output logic [WORD_W-1:0] ewdata_o,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic [WORD_W-1:0] eng_rdata_i,
  output logic [1:0]        wst_o,
  output logic              rvalid_o,
  output logic              hi_sel_o,
  output logic [7:0]        ptr_o
);
  logic [7:0]        ptr_q, lo_q, hi_q;
  logic [1:0]        wst_q;
  logic              mode_q;
  logic [WORD_W-1:0] rword_q;
  logic              rvalid_q, hi_sel_q;
  logic              fetch_pend_q, wr_pend_q, act_wr_q;
  logic              hw_ptr, hw_wd, hw_ws, hr_rd, hi_read, ptr_upd;

  assign hw_ptr  = wr_i && (addr_i == REG_PTR);
  assign hw_wd   = wr_i && (addr_i == REG_WDATA);
  assign hw_ws   = wr_i && (addr_i == REG_WSTAT);
  assign hr_rd   = rd_i && (addr_i == REG_RDATA);
  assign hi_read = hr_rd && rvalid_q && hi_sel_q;
  assign ptr_upd = hw_ptr || hi_read;

  // write has priority over a pending fetch
  assign start_o  = !eng_busy_i && (wr_pend_q || fetch_pend_q);
  assign is_wr_o  = wr_pend_q;
  assign eaddr_o  = ptr_q[ADDR_W-1:0];
  assign ewdata_o = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q        <= '0;
      lo_q         <= '0;
      hi_q         <= '0;
      wst_q        <= 2'b11;
      mode_q       <= 1'b0;
      rword_q      <= '0;
      rvalid_q     <= 1'b0;
      hi_sel_q     <= 1'b0;
      fetch_pend_q <= 1'b0;
      wr_pend_q    <= 1'b0;
      act_wr_q     <= 1'b0;
    end else begin
      if (start_o) begin
        act_wr_q <= is_wr_o;
        if (is_wr_o) wr_pend_q <= 1'b0;
        else         fetch_pend_q <= 1'b0;
      end
      if (eng_done_i) begin
        if (act_wr_q) begin
          wst_q <= 2'b11;
        end else if (!fetch_pend_q && !ptr_upd) begin
          rword_q  <= eng_rdata_i;
          rvalid_q <= 1'b1;
          hi_sel_q <= 1'b0;
        end
      end
      if (hw_wd) begin
        if (wst_q == 2'b11) begin
          lo_q  <= wdata_i;
          wst_q <= 2'b10;
        end else if (wst_q == 2'b10) begin
          hi_q      <= wdata_i;
          wst_q     <= 2'b00;
          wr_pend_q <= 1'b1;
        end
      end
      if (hw_ws) mode_q <= wdata_i[7];
      if (hr_rd && rvalid_q && !hi_sel_q) hi_sel_q <= 1'b1;
      if (hw_ptr)  ptr_q <= wdata_i;
      if (hi_read) ptr_q <= ptr_q + 8'd1;
      if (ptr_upd) begin
        rvalid_q <= 1'b0;
        hi_sel_q <= 1'b0;
        if (!mode_q) fetch_pend_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_PTR:   rdata_o = ptr_q;
      REG_WSTAT: rdata_o = {mode_q, 5'b0, wst_q};
      REG_RDATA: rdata_o = hi_sel_q ? rword_q[15:8] : rword_q[7:0];
      REG_RSTAT: rdata_o = {7'b0, rvalid_q};
      default:   rdata_o = 8'h00;
    endcase
  end

  assign wst_o    = wst_q;
  assign rvalid_o = rvalid_q;
  assign hi_sel_o = hi_sel_q;
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/seeprom_bridge.sv
module seeprom_bridge
  import seeprom_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       cs_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  input  logic       rdy_i
);
  logic              start, is_wr, eng_busy, eng_done;
  logic [ADDR_W-1:0] eaddr;
  logic [WORD_W-1:0] ewdata, erdata;
  logic [1:0]        wst;
  logic              rvalid, hi_sel;
  logic [7:0]        ptr;

  seeprom_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .start_o(start), .is_wr_o(is_wr), .eaddr_o(eaddr), .ewdata_o(ewdata),
    .eng_busy_i(eng_busy), .eng_done_i(eng_done), .eng_rdata_i(erdata),
    .wst_o(wst), .rvalid_o(rvalid), .hi_sel_o(hi_sel), .ptr_o(ptr)
  );

  seeprom_shifter #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk_i, .rst_ni,
    .start_i(start), .is_wr_i(is_wr), .addr_i(eaddr), .wdata_i(ewdata),
    .busy_o(eng_busy), .done_o(eng_done), .rdata_o(erdata),
    .cs_o, .sck_o, .mosi_o, .miso_i, .rdy_i
  );
endmodule

// File: rtl/seeprom_bridge_chk.sv
module seeprom_bridge_chk
  import seeprom_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       cs_o,
  input logic       sck_o,
  input logic [1:0] wst,
  input logic       rvalid,
  input logic       hi_sel,
  input logic [7:0] ptr
);
  assert_wst_low_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_WDATA && wst == 2'b11) |=> wst == 2'b10);

  assert_wst_high_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_WDATA && wst == 2'b10) |=> wst == 2'b00);

  assert_busy_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_WDATA && wst == 2'b00) |=> wst != 2'b10);

  assert_wst_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_WSTAT) |-> rdata_o[6:2] == 5'b0);

  assert_rstat_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_RSTAT) |-> rdata_o[7:1] == 7'b0);

  assert_hi_read_advance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == REG_RDATA && rvalid && hi_sel)
      |=> (!rvalid && ptr == $past(ptr) + 8'd1));

  assert_invalid_read_inert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == REG_RDATA && !rvalid) |=> ptr == $past(ptr));

  assert_sck_inside_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> cs_o);
endmodule

bind seeprom_bridge seeprom_bridge_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .rdata_o(rdata_o), .cs_o(cs_o), .sck_o(sck_o),
  .wst(wst), .rvalid(rvalid), .hi_sel(hi_sel), .ptr(ptr)
);

// File: tb/seeprom_bridge_tb.sv
module seeprom_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int CD   = 2;
  localparam int HDR  = 3 + AW;
  localparam int NB   = HDR + 16;
  localparam int WAIT_LIM = 4 * CD * NB + 60;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       cs_o, sck_o, mosi_o;
  logic       miso_i = 1'b0;
  logic       rdy_i = 1'b1;

  int n_chk = 0, n_fail = 0, frames = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seeprom_bridge #(.ADDR_W(AW), .CLK_DIV(CD)) dut_i (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .cs_o, .sck_o, .mosi_o, .miso_i, .rdy_i
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int w);
    return 16'(w * 16'h1357) ^ 16'hA5C3;
  endfunction

  // device model
  logic [15:0] m_mem [1<<AW];
  logic [31:0] m_sr = '0;
  int          m_cnt = 0;
  logic [2:0]  m_op = '0;
  logic [AW-1:0] m_a = '0;
  logic [15:0] m_wd;

  always @(posedge cs_o) begin m_cnt = 0; m_sr = '0; end
  always @(posedge sck_o) if (cs_o) begin m_sr = {m_sr[30:0], mosi_o}; m_cnt++; end
  always @(negedge sck_o) if (cs_o) begin
    if (m_cnt == HDR) begin
      m_op = m_sr[HDR-1 -: 3];
      m_a  = m_sr[AW-1:0];
    end
    if (m_op == 3'b110 && m_cnt >= HDR && m_cnt < NB)
      miso_i = m_mem[m_a][15 - (m_cnt - HDR)];
  end
  always @(negedge cs_o) begin
    frames++;
    chk("R10 frame length", 16'(m_cnt), 16'(NB));
    chk("R10 command code", 16'(m_op == 3'b110 || m_op == 3'b101), 16'd1);
    if (m_op == 3'b101) begin
      m_wd  = m_sr[15:0];
      rdy_i = 1'b0;
      repeat (20) @(posedge clk_i);
      m_mem[m_a] = m_wd;
      rdy_i = 1'b1;
    end
  end

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk_i);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic wait_wready(input string tag);
    logic [7:0] v;
    int n = 0;
    do begin peek(3'd2, v); n++; end while (v[1:0] != 2'b11 && n < WAIT_LIM);
    chk(tag, 16'(v[1:0]), 16'h3);
  endtask

  task automatic wait_rvalid(input string tag);
    logic [7:0] v;
    int n = 0;
    do begin peek(3'd4, v); n++; end while (!v[0] && n < WAIT_LIM);
    chk(tag, 16'(v), 16'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, lo, hi;
    int f0;
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    peek(3'd2, v); chk("R1 write status", 16'(v), 16'h03);
    peek(3'd4, v); chk("R1 read status", 16'(v), 16'h00);
    peek(3'd0, v); chk("R1 pointer", 16'(v), 16'h00);
    chk("R1 chip select idle", 16'(cs_o), 16'h0);

    // R5 mode bit and reserved bits
    host_wr(3'd2, 8'h80);
    peek(3'd2, v); chk("R5 write mode set", 16'(v), 16'h83);
    host_wr(3'd2, 8'hFF);
    peek(3'd2, v); chk("R5 reserved zero", 16'(v), 16'h83);

    // write sweep in write mode
    for (int w = 0; w < (1 << AW); w++) begin
      f0 = frames;
      host_wr(3'd0, 8'(w));
      peek(3'd4, v); chk("R9 no valid in write mode", 16'(v), 16'h0);
      host_wr(3'd1, pat(w)[7:0]);
      peek(3'd2, v); chk("R2 low byte taken", 16'(v), 16'h82);
      chk("R9 no frame on pointer write", 16'(frames), 16'(f0));
      host_wr(3'd1, pat(w)[15:8]);
      peek(3'd2, v); chk("R3 high byte taken", 16'(v), 16'h80);
      if (w == 3) begin
        host_wr(3'd1, 8'hEE);
        peek(3'd2, v); chk("R4 busy write ignored", 16'(v), 16'h80);
      end
      if (w == 0) begin
        @(negedge cs_o);
        repeat (10) @(negedge clk_i);
        peek(3'd2, v); chk("R11 held while device busy", 16'(v), 16'h80);
      end
      wait_wready("R3 write completes");
    end

    // read sweep in read mode with auto-increment
    host_wr(3'd2, 8'h00);
    peek(3'd2, v); chk("R5 read mode set", 16'(v), 16'h03);
    host_wr(3'd0, 8'h00);
    peek(3'd4, v); chk("R6 valid clear after pointer write", 16'(v), 16'h0);
    wait_rvalid("R6 fetch completes");
    for (int w = 0; w < (1 << AW); w++) begin
      host_rd(3'd3, lo); chk("R6 low byte", 16'(lo), 16'(pat(w)[7:0]));
      host_rd(3'd3, hi); chk("R6 high byte", 16'(hi), 16'(pat(w)[15:8]));
      peek(3'd4, v); chk("R7 valid cleared", 16'(v), 16'h0);
      peek(3'd0, v); chk("R7 pointer advanced", 16'(v), 16'(w + 1));
      if (w == 5) begin
        host_rd(3'd3, v);
        peek(3'd0, v); chk("R8 pointer unchanged", 16'(v), 16'(w + 1));
      end
      if (w < (1 << AW) - 1) wait_rvalid("R7 next word fetched");
    end

    // R12 pointer rewrite during an active fetch
    wait_rvalid("R7 wrap fetch");
    host_wr(3'd0, 8'd2);
    repeat (6) @(negedge clk_i);
    chk("R12 fetch in flight", 16'(cs_o), 16'h1);
    host_wr(3'd0, 8'd9);
    peek(3'd4, v); chk("R12 valid clear", 16'(v), 16'h0);
    wait_rvalid("R12 refetch");
    host_rd(3'd3, lo); chk("R12 low byte new word", 16'(lo), 16'(pat(9)[7:0]));
    host_rd(3'd3, hi); chk("R12 high byte new word", 16'(hi), 16'(pat(9)[15:8]));

    // R9 write mode suppresses fetch after pointer write
    wait_rvalid("R7 fetch before mode change");
    host_wr(3'd2, 8'h80);
    f0 = frames;
    host_wr(3'd0, 8'd4);
    repeat (3 * CD * NB) @(negedge clk_i);
    chk("R9 no fetch frame", 16'(frames), 16'(f0));
    peek(3'd4, v); chk("R9 valid stays clear", 16'(v), 16'h0);

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule